// File: doc/BRIEF.md
# Register-Triggered Dual-Port Bus Bridge

This block is an APB slave with a 4 KB register window. Software uses it to run single read or write transactions on one of two downstream peripheral bus ports. Each port has its own set of setup registers: an enable bit that picks the port, a direction bit, a transfer-width code, an address and write data. Writing the trigger register launches one transaction on the port whose enable bit is the only one set.

Each downstream port is a simple request/acknowledge master. The block holds the request and its descriptor steady until the port acknowledges. A good acknowledge sets a sticky per-port status bit, and a read also places the returned data into that port's read-data register. An error acknowledge leaves both untouched. The interrupt output is the OR of the two status bits. Software clears the status bits by writing ones to them. Register accesses always finish without wait states. A trigger that arrives while a transaction is outstanding is dropped, not queued.

Top module: `apb_trig_bridge`

## Requirements
- R1: After reset the word at 0x00 reads 0x000000A1. The words at 0x4C/0x50/0x54/0x58/0x5C/0x60 read 0x0044EEE4/0x0055AAFF/0x00117717/0xFFAA5500/0x0044EEE4/0x00117717. Every other word reads 0, irq_o is 0, no request is raised, and pready_o is always 1.
- R2: Every 32-bit word write at an offset in 0x00..0x9C stores the written value, and this includes the trigger register at 0x04. Reads at offsets above 0x9C return 0, and writes there are ignored. The status word at 0x48 is the only exception (R9).
- R3: A write to 0x04 while idle, with exactly one port enabled, raises that port's dn_req_o in the cycle after the APB access phase. Port 0 is enabled by bit 0 of 0x10 and port 1 by bit 0 of 0x28. The descriptor is taken from that port's registers: mode at 0x14/0x2C, xfer at 0x18/0x30, address at 0x1C/0x34 and write data at 0x20/0x38. dn_we_o is the inverse of mode bit 0, because 1 means read.
- R4: A trigger with neither port enabled, or with both enabled, raises no request.
- R5: The xfer value 0, 1 or 3 selects a transfer of 1, 2 or 4 bytes, and dn_size_o carries the byte count minus one. Any other xfer value raises no request.
- R6: A raised request keeps its request bit, address, data, direction and size unchanged until the cycle in which dn_ack_i is seen. A trigger written while a request is outstanding launches nothing, either then or later.
- R7: A read acknowledged without error stores dn_rdata_i into 0x84 for port 0 or 0x90 for port 1. The value is zero-extended above the transfer size.
- R8: An error-free acknowledge sets status bit 16 for port 0 or bit 17 for port 1 at 0x48. These bits stay set across later transactions. An acknowledge with dn_err_i set changes neither the status bits nor the read data.
- R9: Writing 1 to status bit 16 or 17 at 0x48 clears that bit, and writing 0 leaves it. irq_o is 1 exactly when either status bit is set.
- R10: At most one port request is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | 12 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| irq_o | output | 1 | OR of the status bits |
| dn_req_o | output | 2 | Per-port request |
| dn_we_o | output | 2 | Per-port write direction |
| dn_size_o | output | 2x2 | Per-port byte count minus one |
| dn_addr_o | output | 2x32 | Per-port address |
| dn_wdata_o | output | 2x32 | Per-port write data |
| dn_ack_i | input | 2 | Per-port acknowledge |
| dn_err_i | input | 2 | Per-port error, valid with ack |
| dn_rdata_i | input | 2x32 | Per-port read data, valid with ack |

## Verification
If the in-flight flag were stuck or lost, it would show up in one of two ways. The request would not drop on the cycle after an acknowledge, or a trigger written during a transaction would replace the descriptor in the next cycle. Both are visible at dn_req_o and dn_addr_o one clock later. A wrong port index or a wrong capture would put the status bit or the read data at the other port's offset. Software sees that on its first read after the acknowledge, and irq_o shows a missed set one cycle after it. Width and select decoding errors appear at dn_size_o and dn_req_o in the cycle right after the trigger write.

// File: rtl/apb_trig_pkg.sv
package apb_trig_pkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned STAT_LSB  = 16;

  // word indexes
  localparam int unsigned OFS_VERSION = 0;
  localparam int unsigned OFS_TRIG    = 1;
  localparam int unsigned OFS_STATUS  = 18;

  // per-port layout: enable, mode, xfer, addr, wdata
  localparam int unsigned FLD_SEL   = 0;
  localparam int unsigned FLD_MODE  = 1;
  localparam int unsigned FLD_XFER  = 2;
  localparam int unsigned FLD_ADDR  = 3;
  localparam int unsigned FLD_WDATA = 4;

  typedef struct packed {
    logic              sel;
    logic              rd;
    logic [WORD_W-1:0] xfer;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
  } port_cfg_t;

  typedef struct packed {
    logic              we;
    logic [1:0]        size;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
  } txn_t;

  function automatic int unsigned port_base(int unsigned p);
    return (p == 0) ? 4 : 10;
  endfunction

  function automatic int unsigned rdata_idx(int unsigned p);
    return (p == 0) ? 33 : 36;
  endfunction

  function automatic logic [WORD_W-1:0] reg_reset_val(int unsigned idx);
    case (idx)
      0:       return 32'h0000_00A1;
      19:      return 32'h0044_EEE4;
      20:      return 32'h0055_AAFF;
      21:      return 32'h0011_7717;
      22:      return 32'hFFAA_5500;
      23:      return 32'h0044_EEE4;
      24:      return 32'h0011_7717;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/apb_trig_regfile.sv
module apb_trig_regfile
  import apb_trig_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 40,
  parameter int unsigned N_PORTS  = NUM_PORTS
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      psel_i,
  input  logic                      penable_i,
  input  logic                      pwrite_i,
  input  logic [ADDR_W-1:0]         paddr_i,
  input  logic [WORD_W-1:0]         pwdata_i,
  output logic [WORD_W-1:0]         prdata_o,
  output logic                      trig_o,
  output port_cfg_t [N_PORTS-1:0]   cfg_o,
  input  logic [N_PORTS-1:0]        cap_en_i,
  input  logic [WORD_W-1:0]         cap_data_i,
  input  logic [N_PORTS-1:0]        stat_set_i,
  output logic [N_PORTS-1:0]        stat_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned SEL_W = $clog2(NUM_REGS);

  logic [WORD_W-1:0]  regs_q [NUM_REGS];
  logic [N_PORTS-1:0] stat_q;
  logic [IDX_W-1:0]   idx;
  logic               wr_en;
  logic               in_range;
  logic               stat_hit;
  logic               unused_lsb;

  assign idx        = paddr_i[ADDR_W-1:2];
  assign unused_lsb = ^paddr_i[1:0];
  assign wr_en      = psel_i & penable_i & pwrite_i;
  assign in_range   = idx < IDX_W'(NUM_REGS);
  assign stat_hit   = idx == IDX_W'(OFS_STATUS);
  assign trig_o     = wr_en && (idx == IDX_W'(OFS_TRIG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_reset_val(i);
      stat_q <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_en && idx == IDX_W'(i) && i != OFS_STATUS) regs_q[i] <= pwdata_i;
      end
      // completion capture wins over a same-cycle software write
      for (int p = 0; p < N_PORTS; p++) begin
        if (cap_en_i[p]) regs_q[rdata_idx(p)] <= cap_data_i;
        if (stat_set_i[p])
          stat_q[p] <= 1'b1;
        else if (wr_en && stat_hit && pwdata_i[STAT_LSB+p])
          stat_q[p] <= 1'b0;
      end
    end
  end

  always_comb begin
    prdata_o = '0;
    if (in_range) begin
      if (stat_hit) prdata_o[STAT_LSB +: N_PORTS] = stat_q;
      else          prdata_o = regs_q[idx[SEL_W-1:0]];
    end
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_cfg
    assign cfg_o[p].sel   = regs_q[port_base(p) + FLD_SEL][0];
    assign cfg_o[p].rd    = regs_q[port_base(p) + FLD_MODE][0];
    assign cfg_o[p].xfer  = regs_q[port_base(p) + FLD_XFER];
    assign cfg_o[p].addr  = regs_q[port_base(p) + FLD_ADDR];
    assign cfg_o[p].wdata = regs_q[port_base(p) + FLD_WDATA];
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/apb_trig_launcher.sv
module apb_trig_launcher
  import apb_trig_pkg::*;
#(
  parameter int unsigned N_PORTS = NUM_PORTS,
  localparam int unsigned PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    trig_i,
  input  port_cfg_t [N_PORTS-1:0] cfg_i,
  output logic                    busy_o,
  output logic [PORT_W-1:0]       port_o,
  output txn_t                    txn_o,
  input  logic                    done_i,
  input  logic                    err_i,
  input  logic [WORD_W-1:0]       rdata_i,
  output logic [N_PORTS-1:0]      stat_set_o,
  output logic [N_PORTS-1:0]      cap_en_o,
  output logic [WORD_W-1:0]       cap_data_o
);
  logic [N_PORTS-1:0] sel_vec;
  logic [PORT_W-1:0]  pick;
  logic [WORD_W-1:0]  xfer;
  logic               size_ok;
  logic               launch;
  logic               busy_q;
  logic [PORT_W-1:0]  port_q;
  txn_t               txn_q;

  always_comb begin
    pick = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      sel_vec[p] = cfg_i[p].sel;
      if (cfg_i[p].sel) pick = PORT_W'(p);
    end
  end

  assign xfer    = cfg_i[pick].xfer;
  assign size_ok = (xfer == 32'd0) || (xfer == 32'd1) || (xfer == 32'd3);
  assign launch  = trig_i && !busy_q && $onehot(sel_vec) && size_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      port_q <= '0;
      txn_q  <= '0;
    end else if (launch) begin
      busy_q     <= 1'b1;
      port_q     <= pick;
      txn_q.we   <= !cfg_i[pick].rd;
      txn_q.size <= xfer[1:0];
      txn_q.addr <= cfg_i[pick].addr;
      txn_q.wdata <= cfg_i[pick].wdata;
    end else if (busy_q && done_i) begin
      busy_q <= 1'b0;
    end
  end

  always_comb begin
    case (txn_q.size)
      2'd0:    cap_data_o = {{(WORD_W-8){1'b0}}, rdata_i[7:0]};
      2'd1:    cap_data_o = {{(WORD_W-16){1'b0}}, rdata_i[15:0]};
      default: cap_data_o = rdata_i;
    endcase
    for (int p = 0; p < N_PORTS; p++) begin
      stat_set_o[p] = busy_q && done_i && !err_i && (port_q == PORT_W'(p));
      cap_en_o[p]   = stat_set_o[p] && !txn_q.we;
    end
  end

  assign busy_o = busy_q;
  assign port_o = port_q;
  assign txn_o  = txn_q;
endmodule

// File: rtl/apb_trig_port.sv
module apb_trig_port
  import apb_trig_pkg::*;
(
  input  logic              active_i,
  input  txn_t              txn_i,
  output logic              req_o,
  output logic              we_o,
  output logic [1:0]        size_o,
  output logic [WORD_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic              err_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] rdata_o
);
  assign req_o   = active_i;
  assign we_o    = active_i & txn_i.we;
  assign size_o  = active_i ? txn_i.size  : '0;
  assign addr_o  = active_i ? txn_i.addr  : '0;
  assign wdata_o = active_i ? txn_i.wdata : '0;
  // responses only count from the port that owns the transaction
  assign done_o  = active_i & ack_i;
  assign err_o   = done_o & err_i;
  assign rdata_o = done_o ? rdata_i : '0;
endmodule

// File: rtl/apb_trig_bridge.sv
module apb_trig_bridge
  import apb_trig_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             psel_i,
  input  logic             penable_i,
  input  logic             pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]      pwdata_i,
  output logic [31:0]      prdata_o,
  output logic             pready_o,
  output logic             irq_o,
  output logic [1:0]       dn_req_o,
  output logic [1:0]       dn_we_o,
  output logic [1:0][1:0]  dn_size_o,
  output logic [1:0][31:0] dn_addr_o,
  output logic [1:0][31:0] dn_wdata_o,
  input  logic [1:0]       dn_ack_i,
  input  logic [1:0]       dn_err_i,
  input  logic [1:0][31:0] dn_rdata_i
);
  localparam int unsigned N_PORTS = NUM_PORTS;
  localparam int unsigned PORT_W  = $clog2(N_PORTS);

  logic                    trig;
  port_cfg_t [N_PORTS-1:0] cfg;
  logic [N_PORTS-1:0]      cap_en, stat_set, stat;
  logic [WORD_W-1:0]       cap_data;
  logic                    busy;
  logic [PORT_W-1:0]       port;
  txn_t                    txn;
  logic [N_PORTS-1:0]      p_done, p_err;
  logic [N_PORTS-1:0][WORD_W-1:0] p_rdata;
  logic                    done, err;
  logic [WORD_W-1:0]       rdata;

  apb_trig_regfile #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .N_PORTS(N_PORTS)
  ) i_regfile (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i,
    .prdata_o,
    .trig_o     (trig),
    .cfg_o      (cfg),
    .cap_en_i   (cap_en),
    .cap_data_i (cap_data),
    .stat_set_i (stat_set),
    .stat_o     (stat)
  );

  apb_trig_launcher #(.N_PORTS(N_PORTS)) i_launcher (
    .clk_i, .rst_ni,
    .trig_i     (trig),
    .cfg_i      (cfg),
    .busy_o     (busy),
    .port_o     (port),
    .txn_o      (txn),
    .done_i     (done),
    .err_i      (err),
    .rdata_i    (rdata),
    .stat_set_o (stat_set),
    .cap_en_o   (cap_en),
    .cap_data_o (cap_data)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    apb_trig_port i_port (
      .active_i (busy && port == PORT_W'(p)),
      .txn_i    (txn),
      .req_o    (dn_req_o[p]),
      .we_o     (dn_we_o[p]),
      .size_o   (dn_size_o[p]),
      .addr_o   (dn_addr_o[p]),
      .wdata_o  (dn_wdata_o[p]),
      .ack_i    (dn_ack_i[p]),
      .err_i    (dn_err_i[p]),
      .rdata_i  (dn_rdata_i[p]),
      .done_o   (p_done[p]),
      .err_o    (p_err[p]),
      .rdata_o  (p_rdata[p])
    );
  end

  always_comb begin
    rdata = '0;
    for (int p = 0; p < N_PORTS; p++) rdata |= p_rdata[p];
  end

  assign done     = |p_done;
  assign err      = |p_err;
  assign irq_o    = |stat;
  assign pready_o = 1'b1;
endmodule

// File: rtl/apb_trig_bridge_chk.sv
module apb_trig_bridge_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             psel_i,
  input logic             penable_i,
  input logic             pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic             pready_o,
  input logic             irq_o,
  input logic [1:0]       dn_req_o,
  input logic [1:0]       dn_we_o,
  input logic [1:0][1:0]  dn_size_o,
  input logic [1:0][31:0] dn_addr_o,
  input logic [1:0][31:0] dn_wdata_o,
  input logic [1:0]       dn_ack_i,
  input logic [1:0]       dn_err_i
);
  logic trig_wr;
  assign trig_wr = psel_i && penable_i && pwrite_i && (paddr_i[ADDR_W-1:2] == '0 + 1);

  // R1
  ready_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) pready_o);

  // R10
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(dn_req_o));

  // R3
  launch_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|dn_req_o) |-> $past(trig_wr));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(dn_req_o & ~dn_ack_i)) |=> ($stable(dn_req_o) && $stable(dn_addr_o) &&
      $stable(dn_wdata_o) && $stable(dn_we_o) && $stable(dn_size_o)));

  // R5
  size_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_req_o[0] |-> dn_size_o[0] != 2'b10) and (dn_req_o[1] |-> dn_size_o[1] != 2'b10));

  // R8
  stat_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(dn_req_o & dn_ack_i & ~dn_err_i)) |=> irq_o);
endmodule

bind apb_trig_bridge apb_trig_bridge_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_apb_trig_bridge.sv
module test_apb_trig_bridge;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic psel_i = 0, penable_i = 0, pwrite_i = 0;
  logic [11:0] paddr_i = '0;
  logic [31:0] pwdata_i = '0, prdata_o;
  logic pready_o, irq_o;
  logic [1:0] dn_req_o, dn_we_o;
  logic [1:0][1:0] dn_size_o;
  logic [1:0][31:0] dn_addr_o, dn_wdata_o;
  logic [1:0] dn_ack_i = '0, dn_err_i = '0;
  logic [1:0][31:0] dn_rdata_i = '0;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  apb_trig_bridge i_apb_trig_bridge (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    psel_i = 1; pwrite_i = 1; penable_i = 0; paddr_i = a; pwdata_i = d;
    @(negedge clk_i);
    penable_i = 1;
    @(negedge clk_i);
    psel_i = 0; penable_i = 0; pwrite_i = 0;
  endtask

  task automatic apb_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    psel_i = 1; pwrite_i = 0; penable_i = 0; paddr_i = a;
    @(negedge clk_i);
    penable_i = 1;
    #1 d = prdata_o;
    @(negedge clk_i);
    psel_i = 0; penable_i = 0;
  endtask

  task automatic rd_check(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    apb_read(a, d);
    check(req, d, exp);
  endtask

  task automatic ack_port(int p, logic e, logic [31:0] rd);
    @(negedge clk_i);
    dn_ack_i[p] = 1; dn_err_i[p] = e; dn_rdata_i[p] = rd;
    @(negedge clk_i);
    dn_ack_i = '0; dn_err_i = '0;
  endtask

  task automatic t_reset();
    check("R1 req", {30'b0, dn_req_o}, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 pready", {31'b0, pready_o}, 1);
    rd_check("R1 version", 12'h000, 32'h0000_00A1);
    rd_check("R1 ord4c", 12'h04C, 32'h0044_EEE4);
    rd_check("R1 ord50", 12'h050, 32'h0055_AAFF);
    rd_check("R1 ord54", 12'h054, 32'h0011_7717);
    rd_check("R1 ord58", 12'h058, 32'hFFAA_5500);
    rd_check("R1 ord5c", 12'h05C, 32'h0044_EEE4);
    rd_check("R1 ord60", 12'h060, 32'h0011_7717);
    rd_check("R1 sel0", 12'h010, 0);
    rd_check("R1 status", 12'h048, 0);
  endtask

  task automatic t_regs();
    apb_write(12'h040, 32'hDEAD_BEEF);
    rd_check("R2 plain", 12'h040, 32'hDEAD_BEEF);
    apb_write(12'h09C, 32'h1357_9BDF);
    rd_check("R2 last", 12'h09C, 32'h1357_9BDF);
    apb_write(12'h0A0, 32'hFFFF_FFFF);
    rd_check("R2 beyond", 12'h0A0, 0);
    rd_check("R2 far", 12'hFFC, 0);
    check("R2 no req", {30'b0, dn_req_o}, 0);
  endtask

  task automatic t_write_p0();
    apb_write(12'h010, 1);
    apb_write(12'h014, 0);
    apb_write(12'h018, 3);
    apb_write(12'h01C, 32'h0000_1234);
    apb_write(12'h020, 32'hCAFE_F00D);
    apb_write(12'h004, 32'h0000_0001);
    check("R3 req0", {30'b0, dn_req_o}, 2'b01);
    check("R3 we", {31'b0, dn_we_o[0]}, 1);
    check("R5 size4", {30'b0, dn_size_o[0]}, 3);
    check("R3 addr", dn_addr_o[0], 32'h0000_1234);
    check("R3 wdata", dn_wdata_o[0], 32'hCAFE_F00D);
    apb_write(12'h01C, 32'h0000_5555);
    apb_write(12'h004, 32'h0000_0077);
    check("R6 held req", {30'b0, dn_req_o}, 2'b01);
    check("R6 held addr", dn_addr_o[0], 32'h0000_1234);
    rd_check("R2 trig stored", 12'h004, 32'h0000_0077);
    ack_port(0, 0, 32'hFFFF_FFFF);
    check("R6 dropped", {30'b0, dn_req_o}, 0);
    check("R9 irq", {31'b0, irq_o}, 1);
    rd_check("R8 stat0", 12'h048, 32'h0001_0000);
    rd_check("R7 write no cap", 12'h084, 0);
  endtask

  task automatic t_read_p1();
    apb_write(12'h010, 0);
    apb_write(12'h028, 1);
    apb_write(12'h02C, 1);
    apb_write(12'h030, 0);
    apb_write(12'h034, 32'h8000_0010);
    apb_write(12'h004, 1);
    check("R3 req1", {30'b0, dn_req_o}, 2'b10);
    check("R3 rd dir", {31'b0, dn_we_o[1]}, 0);
    check("R5 size1", {30'b0, dn_size_o[1]}, 0);
    check("R3 addr1", dn_addr_o[1], 32'h8000_0010);
    ack_port(1, 0, 32'hA5A5_5AC3);
    rd_check("R7 byte", 12'h090, 32'h0000_00C3);
    rd_check("R8 sticky", 12'h048, 32'h0003_0000);
    apb_write(12'h030, 1);
    apb_write(12'h004, 1);
    check("R5 size2", {30'b0, dn_size_o[1]}, 1);
    ack_port(1, 0, 32'h1234_5678);
    rd_check("R7 half", 12'h090, 32'h0000_5678);
  endtask

  task automatic t_clear_err();
    apb_write(12'h048, 32'h0001_0000);
    rd_check("R9 clr0", 12'h048, 32'h0002_0000);
    check("R9 irq on", {31'b0, irq_o}, 1);
    apb_write(12'h048, 32'h0002_0000);
    check("R9 irq off", {31'b0, irq_o}, 0);
    apb_write(12'h004, 1);
    check("R8 err req", {30'b0, dn_req_o}, 2'b10);
    ack_port(1, 1, 32'hFFFF_FFFF);
    check("R8 err no irq", {31'b0, irq_o}, 0);
    rd_check("R8 err stat", 12'h048, 0);
    rd_check("R8 err rdata", 12'h090, 32'h0000_5678);
  endtask

  task automatic t_invalid();
    apb_write(12'h010, 1);
    apb_write(12'h004, 1);
    check("R4 both", {30'b0, dn_req_o}, 0);
    apb_write(12'h010, 0);
    apb_write(12'h028, 0);
    apb_write(12'h004, 1);
    check("R4 none", {30'b0, dn_req_o}, 0);
    apb_write(12'h028, 1);
    apb_write(12'h030, 2);
    apb_write(12'h004, 1);
    check("R5 code2", {30'b0, dn_req_o}, 0);
    apb_write(12'h030, 32'h0000_0007);
    apb_write(12'h004, 1);
    check("R5 high bit", {30'b0, dn_req_o}, 0);
    apb_write(12'h030, 3);
    apb_write(12'h004, 1);
    check("R10 one req", {30'b0, dn_req_o}, 2'b10);
    ack_port(1, 0, 32'h89AB_CDEF);
    rd_check("R7 word", 12'h090, 32'h89AB_CDEF);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_write_p0();
    t_read_p1();
    t_clear_err();
    t_invalid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule